// File: doc/BRIEF.md
# Timer-Latched Bidirectional GPIO Port

This block is an eight-pin general-purpose port. Each pin can be an input or an output, and each output can be push-pull or open-drain. Output data passes through two register stages. A bus write lands in a preload register. Each four-bit half of the preload then moves to the output register only when that half's chosen timing event arrives. The event is either an internal half-rate enable or one of three timer pulses. Because of this, software can stage a new pattern ahead of time and have it reach the pins on an exact timer edge.

Eight extra write addresses each change a single preload bit, so one pin can be changed without a read-modify-write. A function register lets two serial transmit signals take over pins 6 and 4. Reading the data address returns the pin levels after a synchronizer. The timers are outside the block and deliver single-cycle pulses.

Top module: `gpio_tl_port`

## Requirements
- R1: After reset the direction register is all zeros, so `pin_oe` is 0 on every pin. Both half-selects are 00, so both halves transfer on the half-rate enable.
- R2: A direction bit of 1 enables the driver of that pin. A push-pull output drives its output value on `pin_out` with `pin_oe` high. A pin whose direction bit is 0 has `pin_oe` low.
- R3: A write to offset 0 loads only the preload register. Each half of the output register changes only at an edge where that half's event is active, and it then takes the preload value from before that edge.
- R4: Control offset 4 holds the event selects. Bits 1:0 select the event for pins 3:0 and bits 5:4 select the event for pins 7:4. The codes are 00 = half-rate enable, 01 = `tmr_a1`, 10 = `tmr_b1`, 11 = `tmr_b2`.
- R5: The half-rate enable is low in the first cycle after reset and toggles every clock. Half-rate transfers therefore happen at the 2nd, 4th, 6th and later clock edges after reset is released.
- R6: A write to offset 8+n (n = 0..7) sets preload bit n to `bus_wdata[n]` and leaves the other preload bits unchanged.
- R7: A drive bit of 1 (offset 6) makes that output open-drain. `pin_out` is 0, and `pin_oe` is high only while the pin's output value is 0.
- R8: Function bit 6 (offset 5) makes pin 6 carry `alt_tx_a`. Function bit 4 makes pin 4 carry `alt_tx_b`. The alternate signal bypasses the output register and reaches the pin in the same cycle.
- R9: `bus_rdata` shows the pin levels through a two-flop synchronizer when `bus_addr` selects offset 0, and shows 0 for any other address.
- R10: The block uses a 16-byte window at `BASE` (default 0x60). Offsets are data 0, control 4, function 5, drive 6 and direction 7. A write with any upper-address mismatch has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (synchronized pin levels) |
| tmr_a1 | input | 1 | Timer event pulse, select code 01 |
| tmr_b1 | input | 1 | Timer event pulse, select code 10 |
| tmr_b2 | input | 1 | Timer event pulse, select code 11 |
| alt_tx_a | input | 1 | Alternate serial transmit routed to pin 6 |
| alt_tx_b | input | 1 | Alternate serial transmit routed to pin 4 |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output value to the pads |
| pin_oe | output | 8 | Output enable to the pads |

## Verification
The hardest case to reach is a write to the preload that lands in the same cycle as a transfer event, combined with the two halves following different sources. In that case only one half of the pins should move, and it should move with the old preload value. The stimulus writes random control values so that select codes keep changing during the run. It also raises timer pulses at random, independently of the writes, so writes and events overlap often. A directed sequence sets the low half to one timer and the high half to another, then pulses each timer in turn.

// File: rtl/gpio_tl_pkg.sv
package gpio_tl_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned HALF_W = 4;
    localparam int unsigned N_HALF = PORT_W / HALF_W;
    localparam int unsigned IDX_W  = $clog2(PORT_W);

    localparam logic [3:0] OFS_DATA  = 4'd0;
    localparam logic [3:0] OFS_CTRL  = 4'd4;
    localparam logic [3:0] OFS_FUNC  = 4'd5;
    localparam logic [3:0] OFS_DRIVE = 4'd6;
    localparam logic [3:0] OFS_DIR   = 4'd7;

    localparam int unsigned ALT_A_PIN = 6;
    localparam int unsigned ALT_B_PIN = 4;

    typedef enum logic [1:0] {
        EV_HALF = 2'b00,
        EV_TA1  = 2'b01,
        EV_TB1  = 2'b10,
        EV_TB2  = 2'b11
    } ev_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] pre;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] od;
        logic              fn_a;
        logic              fn_b;
        ev_sel_e           sel_hi;
        ev_sel_e           sel_lo;
    } cfg_t;
endpackage

// File: rtl/gpio_tl_regs.sv
module gpio_tl_regs
    import gpio_tl_pkg::*;
#(
    parameter int unsigned       ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [PORT_W-1:0] wdata,
    output cfg_t              cfg_q
);
    logic       hit;
    logic [3:0] ofs;
    cfg_t       cfg_d;

    assign hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    assign ofs = addr[3:0];

    always_comb begin
        cfg_d = cfg_q;
        if (wr && hit) begin
            if (ofs[3]) begin
                cfg_d.pre[ofs[IDX_W-1:0]] = wdata[ofs[IDX_W-1:0]];
            end else begin
                case (ofs)
                    OFS_DATA:  cfg_d.pre = wdata;
                    OFS_CTRL: begin
                        cfg_d.sel_lo = ev_sel_e'(wdata[1:0]);
                        cfg_d.sel_hi = ev_sel_e'(wdata[5:4]);
                    end
                    OFS_FUNC: begin
                        cfg_d.fn_a = wdata[ALT_A_PIN];
                        cfg_d.fn_b = wdata[ALT_B_PIN];
                    end
                    OFS_DRIVE: cfg_d.od  = wdata;
                    OFS_DIR:   cfg_d.dir = wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R1: direction is clear on the first cycle out of reset
    p_reset_dir_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_q.dir == '0 && cfg_q.sel_lo == EV_HALF && cfg_q.sel_hi == EV_HALF));

    // R6: a bit-register write changes at most one preload bit
    p_bitwrite_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit && ofs[3]) |=> ($countones(cfg_q.pre ^ $past(cfg_q.pre)) <= 1));
endmodule

// File: rtl/gpio_tl_half.sv
module gpio_tl_half
    import gpio_tl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ev_sel_e           sel,
    input  logic [3:0]        ev_src,
    input  logic [HALF_W-1:0] pre,
    output logic [HALF_W-1:0] out_q
);
    logic              ev;
    logic [HALF_W-1:0] out_d;

    always_comb begin
        ev    = ev_src[sel];
        out_d = ev ? pre : out_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // R3: output half holds when its event is absent
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(out_q));
    // R3: on an event the half takes the preload seen at that edge
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (out_q == $past(pre)));
endmodule

// File: rtl/gpio_tl_pins.sv
module gpio_tl_pins
    import gpio_tl_pkg::*;
(
    input  logic [PORT_W-1:0] out_q,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] od,
    input  logic              fn_a,
    input  logic              fn_b,
    input  logic              alt_a,
    input  logic              alt_b,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic val;
        if (i == ALT_A_PIN) begin : g_alt_a
            assign val = fn_a ? alt_a : out_q[i];
        end else if (i == ALT_B_PIN) begin : g_alt_b
            assign val = fn_b ? alt_b : out_q[i];
        end else begin : g_plain
            assign val = out_q[i];
        end
        assign pin_out[i] = val & ~od[i];
        assign pin_oe[i]  = dir[i] & (~od[i] | ~val);
    end
endmodule

// File: rtl/gpio_tl_port.sv
module gpio_tl_port
    import gpio_tl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE  = 'h60,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tmr_a1,
    input  logic              tmr_b1,
    input  logic              tmr_b2,
    input  logic              alt_tx_a,
    input  logic              alt_tx_b,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe
);
    typedef struct packed {
        logic                                half;
        logic [SYNC_STAGES-1:0][PORT_W-1:0]  sync;
    } core_t;

    core_t             core_d, core_q;
    cfg_t              cfg;
    logic [3:0]        ev_src;
    logic [PORT_W-1:0] out_q;

    gpio_tl_regs #(.ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .cfg_q (cfg)
    );

    always_comb begin
        core_d      = core_q;
        core_d.half = ~core_q.half;
        core_d.sync[0] = pin_in;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            core_d.sync[s] = core_q.sync[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign ev_src = {tmr_b2, tmr_b1, tmr_a1, core_q.half};

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        gpio_tl_half u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    ((h == 0) ? cfg.sel_lo : cfg.sel_hi),
            .ev_src (ev_src),
            .pre    (cfg.pre[h*HALF_W +: HALF_W]),
            .out_q  (out_q[h*HALF_W +: HALF_W])
        );
    end

    gpio_tl_pins u_pins (
        .out_q   (out_q),
        .dir     (cfg.dir),
        .od      (cfg.od),
        .fn_a    (cfg.fn_a),
        .fn_b    (cfg.fn_b),
        .alt_a   (alt_tx_a),
        .alt_b   (alt_tx_b),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign bus_rdata = (bus_addr == (BASE | ADDR_W'(OFS_DATA)))
                     ? core_q.sync[SYNC_STAGES-1] : '0;

    // R5: the half-rate enable alternates every cycle once out of reset
    p_half_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (core_q.half != $past(core_q.half)));
endmodule

// File: tb/sim_gpio_tl_port.sv
module sim_gpio_tl_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] BASE = 8'h60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = BASE;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tmr_a1 = 1'b0, tmr_b1 = 1'b0, tmr_b2 = 1'b0;
    logic       alt_tx_a = 1'b0, alt_tx_b = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_tl_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_a1(tmr_a1),
        .tmr_b1(tmr_b1), .tmr_b2(tmr_b2), .alt_tx_a(alt_tx_a),
        .alt_tx_b(alt_tx_b), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // reference state built from the requirements
    logic [7:0] m_pre, m_out, m_dir, m_od, m_s1, m_s2;
    logic       m_fa, m_fb, m_half;
    logic [1:0] m_slo, m_shi;

    function automatic logic ev_of(logic [1:0] s);
        case (s)
            2'b00:   return m_half;
            2'b01:   return tmr_a1;
            2'b10:   return tmr_b1;
            default: return tmr_b2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= '0; m_out <= '0; m_dir <= '0; m_od <= '0;
            m_s1 <= '0; m_s2 <= '0; m_fa <= 1'b0; m_fb <= 1'b0;
            m_half <= 1'b0; m_slo <= '0; m_shi <= '0;
        end else begin
            m_half <= ~m_half;
            if (ev_of(m_slo)) m_out[3:0] <= m_pre[3:0];
            if (ev_of(m_shi)) m_out[7:4] <= m_pre[7:4];
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (bus_wr && bus_addr[7:4] == BASE[7:4]) begin
                if (bus_addr[3]) m_pre[bus_addr[2:0]] <= bus_wdata[bus_addr[2:0]];
                else case (bus_addr[3:0])
                    4'd0: m_pre <= bus_wdata;
                    4'd4: begin m_slo <= bus_wdata[1:0]; m_shi <= bus_wdata[5:4]; end
                    4'd5: begin m_fa <= bus_wdata[6]; m_fb <= bus_wdata[4]; end
                    4'd6: m_od <= bus_wdata;
                    4'd7: m_dir <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_val();
        logic [7:0] v = m_out;
        if (m_fa) v[6] = alt_tx_a;
        if (m_fb) v[4] = alt_tx_b;
        return v;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] v = exp_val();
        chk(pin_out, v & ~m_od, "R2/R3/R7/R8 pin_out");
        chk(pin_oe, m_dir & (~m_od | ~v), "R2/R7 pin_oe");
        chk(bus_rdata, (bus_addr == BASE) ? m_s2 : 8'h00, "R9 bus_rdata");
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = BASE;
    endtask

    initial begin
        repeat (CLK_PERIOD * 150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_oe, 8'h00, "R1 all inputs after reset");
        compare();

        // R10: write outside the window is ignored
        wr(8'h77, 8'hFF);
        tick();
        chk(pin_oe, 8'h00, "R10 out-of-window direction write");

        // R6: single-bit writes, half-rate transfer (R5)
        wr(BASE + 8'd7, 8'hFF);
        wr(BASE + 8'd11, 8'h08);
        tick(); tick();
        chk(pin_out, 8'h08, "R6 bit 3 set");
        wr(BASE + 8'd13, 8'hF7);
        tick(); tick();
        chk(pin_out, 8'h28, "R6 bit 5 set others kept");

        // R4: low half on tmr_a1, high half on tmr_b1
        wr(BASE + 8'd4, 8'h21);
        wr(BASE + 8'd0, 8'h5A);
        tick(); tick(); tick();
        chk(pin_out, 8'h28, "R3 no event no change");
        tmr_a1 = 1'b1; tick(); tmr_a1 = 1'b0;
        chk(pin_out, 8'h2A, "R4 low half on tmr_a1");
        tmr_b2 = 1'b1; tick(); tmr_b2 = 1'b0;
        chk(pin_out, 8'h2A, "R4 high half ignores tmr_b2");
        tmr_b1 = 1'b1; tick(); tmr_b1 = 1'b0;
        chk(pin_out, 8'h5A, "R4 high half on tmr_b1");

        // R8: alternate transmit overrides pin 6
        wr(BASE + 8'd5, 8'h50);
        alt_tx_a = 1'b1; alt_tx_b = 1'b0; #1;
        chk(pin_out & 8'h50, 8'h40, "R8 alternate on pins 6 and 4");

        // R7: open drain
        wr(BASE + 8'd6, 8'h0F);
        chk(pin_oe, 8'hF5, "R7 open-drain enables");

        // R9: synchronizer delay
        pin_in = 8'h3C;
        tick(); tick();
        chk(bus_rdata, 8'h3C, "R9 read after two cycles");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int unsigned r = $urandom;
            logic [3:0] ofs;
            case (r % 13)
                0: ofs = 4'd0; 1: ofs = 4'd4; 2: ofs = 4'd5;
                3: ofs = 4'd6; 4: ofs = 4'd7;
                default: ofs = 4'(8 + (r % 13) - 5);
            endcase
            bus_wr    = ((r >> 4) % 3) == 0;
            bus_addr  = bus_wr ? {(((r >> 8) % 16) == 0) ? 4'h7 : 4'h6, ofs} : BASE;
            bus_wdata = 8'($urandom);
            tmr_a1    = ((r >> 12) % 5) == 0;
            tmr_b1    = ((r >> 15) % 5) == 0;
            tmr_b2    = ((r >> 18) % 5) == 0;
            alt_tx_a  = r[21];
            alt_tx_b  = r[22];
            pin_in    = 8'($urandom);
            tick();
        end
        bus_wr = 1'b0; tmr_a1 = 1'b0; tmr_b1 = 1'b0; tmr_b2 = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule